// File: doc/BRIEF.md
# E3 Maintenance Byte Monitor

This block watches the maintenance-and-adaptation byte taken from each received G.832 E3 frame. An upstream framer hands over one byte per frame on a valid/ready stream. The block takes the byte in the cycle where both `ma_valid` and `ma_ready` are high. `ma_ready` is tied high, so the block never applies back-pressure: the source may present a byte in any cycle, and a byte shown while `ma_valid` is low is not taken.

Three functions act on every accepted byte:
- A payload-type check stores the received 3-bit type and compares it with a programmed expected type. A difference sets a sticky interrupt flag, but only if the interrupt is enabled.
- A persistence filter turns the remote defect indicator bit into a defect state. The filter needs 3 or 5 frames in a row both to declare the defect and to clear it.
- A validator reports the timing marker bit as valid once the bit has kept the same value for 3 or 5 frames in a row.

A small register port carries the configuration and status.

Top module: `e3_ma_monitor`

## Requirements
- R1: After reset, register 0 reads 0x42, register 1 and register 2 read 0x00, and `rdi_defect`, `tm_valid` and `pt_irq` are low.
- R2: Register 0 bits 7:5 hold the payload type of the most recently accepted byte, taken from byte bits 5:3. Bits 7:5 are read-only: a write to them has no effect.
- R3: With register 0 bit 4 = 0, `rdi_defect` rises after byte bit 7 is 1 in 3 accepted frames in a row. It falls after bit 7 is 0 in 3 frames in a row. Any frame that breaks the run restarts the count.
- R4: With register 0 bit 4 = 1, both the declare threshold and the clear threshold are 5 frames in a row.
- R5: With register 0 bit 3 = 0, `tm_valid` goes high once byte bit 0 has held the same value for 3 accepted frames in a row. While `tm_valid` is high, `tm_value` equals that bit. A frame whose bit 0 differs from the previous frame drops `tm_valid`.
- R6: With register 0 bit 3 = 1, the timing marker needs 5 frames in a row before `tm_valid` goes high.
- R7: Suppose register 1 bit 0 (interrupt enable) is 1 and an accepted byte's payload type differs from register 0 bits 2:0. Then register 2 bit 0 and `pt_irq` are set. They stay set until register 2 is written with bit 0 = 1. A write with bit 0 = 0 leaves them set. While the enable is 0, a mismatch does not set them.
- R8: A change of either select bit takes effect at the next accepted frame. It does not reset the current defect state or the timing-marker state.
- R9: `ma_ready` is always high. A byte presented while `ma_valid` is low changes nothing.
- R10: Register 0 bits 4:0 and register 1 bit 0 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma_valid | input | 1 | Maintenance byte present |
| ma_ready | output | 1 | Block accepts a byte (always 1) |
| ma_byte | input | 8 | Maintenance-and-adaptation byte of one frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config/status, 1 interrupt enable, 2 interrupt status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| rdi_defect | output | 1 | Filtered remote defect state |
| tm_valid | output | 1 | Timing marker validated |
| tm_value | output | 1 | Current timing marker value |
| pt_irq | output | 1 | Sticky payload-type mismatch interrupt |

## Verification
The bench tries every 8-frame pattern of the defect bit and of the marker bit under all four select combinations, so runs that break exactly one frame before the threshold are included. A filter that did not restart its count on a broken run, or that used different thresholds for declare and clear, would change state in the wrong frame. The bench switches the thresholds while a defect is declared; a design that reset its state on the switch would drop the defect early. It also sweeps all 64 pairs of received and expected payload type, and tests clear-by-write-one, writes of 0, and the enable gate. A design with a non-sticky flag, or one that ignored the enable, would show a wrong interrupt level.

// File: rtl/e3_ma_pkg.sv
package e3_ma_pkg;
  localparam int          REG_AW     = 2;
  localparam logic [1:0]  ADDR_CFG   = 2'd0;
  localparam logic [1:0]  ADDR_IRQEN = 2'd1;
  localparam logic [1:0]  ADDR_IRQST = 2'd2;
  localparam logic [7:0]  CFG_RESET  = 8'h42;

  typedef struct packed {
    logic       rdi_sel;
    logic       tm_sel;
    logic [2:0] exp_pt;
  } cfg_t;
endpackage

// File: rtl/e3_rdi_filter.sv
module e3_rdi_filter #(
  parameter int THR_LO = 3,
  parameter int THR_HI = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic sample,
  input  logic sel_hi,
  output logic defect
);
  localparam int CW = $clog2(THR_HI + 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;
  logic [CW-1:0] thr;

  assign thr    = sel_hi ? THR_HI[CW-1:0] : THR_LO[CW-1:0];
  assign run_nx = run_q + 1'b1;

  // Count frames disagreeing with current state; flip on reaching threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      defect <= 1'b0;
    end else if (strobe) begin
      if (sample != defect) begin
        if (run_nx >= thr) begin
          defect <= sample;
          run_q  <= '0;
        end else begin
          run_q <= run_nx;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(defect));
  assert_change_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (defect != $past(defect)) |-> ($past(strobe) && $past(sample) == defect));
  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < THR_HI[CW-1:0]);
endmodule

// File: rtl/e3_tm_validator.sv
module e3_tm_validator #(
  parameter int THR_LO = 3,
  parameter int THR_HI = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic sample,
  input  logic sel_hi,
  output logic valid,
  output logic value
);
  localparam int CW = $clog2(THR_HI + 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;
  logic [CW-1:0] thr;

  assign thr = sel_hi ? THR_HI[CW-1:0] : THR_LO[CW-1:0];

  // Length of the current run of equal marker values, saturating.
  always_comb begin
    if (run_q == '0 || sample != value)
      run_nx = {{(CW-1){1'b0}}, 1'b1};
    else if (run_q == THR_HI[CW-1:0])
      run_nx = run_q;
    else
      run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      value <= 1'b0;
      valid <= 1'b0;
    end else if (strobe) begin
      run_q <= run_nx;
      value <= sample;
      valid <= (run_nx >= thr);
    end
  end

  assert_rise_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(strobe));
  assert_valid_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (run_q >= THR_LO[CW-1:0]));
  assert_value_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(value) && $stable(valid)));
endmodule

// File: rtl/e3_pt_checker.sv
module e3_pt_checker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [2:0] pt_in,
  input  logic [2:0] exp_pt,
  input  logic       irq_en,
  input  logic       clr,
  output logic [2:0] rx_pt,
  output logic       flag
);
  logic mismatch;
  assign mismatch = strobe && irq_en && (pt_in != exp_pt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pt <= 3'b010;
      flag  <= 1'b0;
    end else begin
      if (strobe) rx_pt <= pt_in;
      if (mismatch)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
    end
  end

  assert_rx_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(rx_pt));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_gated_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(strobe) && $past(irq_en)));
endmodule

// File: rtl/e3_ma_monitor.sv
module e3_ma_monitor
  import e3_ma_pkg::*;
#(
  parameter int RDI_POS = 7,
  parameter int PT_LSB  = 3,
  parameter int TM_POS  = 0,
  parameter int THR_LO  = 3,
  parameter int THR_HI  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ma_valid,
  output logic              ma_ready,
  input  logic [7:0]        ma_byte,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              rdi_defect,
  output logic              tm_valid,
  output logic              tm_value,
  output logic              pt_irq
);
  cfg_t       cfg_q;
  logic       irq_en_q;
  logic       strobe;
  logic       clr;
  logic [2:0] rx_pt;
  logic       flag;

  assign ma_ready = 1'b1;
  assign strobe   = ma_valid && ma_ready;
  assign clr      = reg_wr && (reg_addr == ADDR_IRQST) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= cfg_t'(CFG_RESET[4:0]);
      irq_en_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CFG)   cfg_q    <= cfg_t'(reg_wdata[4:0]);
      if (reg_addr == ADDR_IRQEN) irq_en_q <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CFG:   reg_rdata = {rx_pt, cfg_q};
      ADDR_IRQEN: reg_rdata = {7'd0, irq_en_q};
      ADDR_IRQST: reg_rdata = {7'd0, flag};
      default:    reg_rdata = 8'd0;
    endcase
  end

  e3_rdi_filter #(.THR_LO(THR_LO), .THR_HI(THR_HI)) u_rdi (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .sample(ma_byte[RDI_POS]), .sel_hi(cfg_q.rdi_sel), .defect(rdi_defect));

  e3_tm_validator #(.THR_LO(THR_LO), .THR_HI(THR_HI)) u_tm (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .sample(ma_byte[TM_POS]), .sel_hi(cfg_q.tm_sel),
    .valid(tm_valid), .value(tm_value));

  e3_pt_checker u_pt (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .pt_in(ma_byte[PT_LSB +: 3]), .exp_pt(cfg_q.exp_pt),
    .irq_en(irq_en_q), .clr(clr), .rx_pt(rx_pt), .flag(flag));

  assign pt_irq = flag;

  assert_cfg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CFG) |=> (cfg_q == $past(reg_wdata[4:0])));
  assert_cfg_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_CFG) |=> $stable(cfg_q));
  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ma_ready);
endmodule

// File: tb/tb_e3_ma_monitor.sv
`timescale 1ns/1ps
module tb_e3_ma_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ma_valid = 1'b0;
  logic       ma_ready;
  logic [7:0] ma_byte = 8'd0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       rdi_defect, tm_valid, tm_value, pt_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e3_ma_monitor dut (
    .clk(clk), .rst_n(rst_n), .ma_valid(ma_valid), .ma_ready(ma_ready),
    .ma_byte(ma_byte), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rdi_defect(rdi_defect),
    .tm_valid(tm_valid), .tm_value(tm_value), .pt_irq(pt_irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ma_valid = 1'b0; reg_wr = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic frame(input logic [7:0] b);
    @(negedge clk); ma_valid = 1'b1; ma_byte = b;
    @(negedge clk); ma_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R1 reset state
    rd(2'd0, d); chk("R1 reg0", d, 8'h42);
    rd(2'd1, d); chk("R1 reg1", d, 0);
    rd(2'd2, d); chk("R1 reg2", d, 0);
    chk("R1 rdi_defect", rdi_defect, 0);
    chk("R1 tm_valid", tm_valid, 0);
    chk("R1 pt_irq", pt_irq, 0);
    chk("R9 ma_ready", ma_ready, 1);

    // R2 payload type capture, all values
    for (int p = 0; p < 8; p++) begin
      frame({2'b00, p[2:0], 3'b000});
      rd(2'd0, d); chk("R2 rx pt", d[7:5], p);
    end
    // R2 read-only field; R10 readback
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 ro field", d[7:5], 7); chk("R10 cfg rb", d[4:0], 5'h1F);
    wr(2'd0, 8'h0D); rd(2'd0, d); chk("R2 ro after write", d[7:5], 7); chk("R10 cfg rb2", d[4:0], 5'h0D);
    wr(2'd1, 8'h01); rd(2'd1, d); chk("R10 irqen rb", d, 1);
    wr(2'd1, 8'h00);

    // R9 byte without valid ignored
    @(negedge clk); ma_valid = 1'b0; ma_byte = 8'hFF;
    @(negedge clk); @(negedge clk);
    rd(2'd0, d); chk("R9 ignored pt", d[7:5], 7);
    frame(8'h00); rd(2'd0, d); chk("R9 accepted pt", d[7:5], 0);
    ma_byte = 8'hFF; @(negedge clk); @(negedge clk);
    rd(2'd0, d); chk("R9 ignored pt2", d[7:5], 0);
    chk("R9 ignored rdi", rdi_defect, 0);

    // R3/R4/R5/R6 exhaustive sweep over 8-frame patterns
    for (int sr = 0; sr < 2; sr++)
      for (int st = 0; st < 2; st++)
        for (int seq = 0; seq < 256; seq++) begin
          int rthr, tthr, rcnt, trun;
          bit rstate, tlast;
          rthr = sr ? 5 : 3; tthr = st ? 5 : 3;
          rcnt = 0; rstate = 0; trun = 0; tlast = 0;
          do_reset();
          wr(2'd0, {3'b000, sr[0], st[0], 3'b010});
          for (int f = 0; f < 8; f++) begin
            bit rb, tb;
            rb = seq[f]; tb = seq[7-f];
            frame({rb, 1'b0, 3'b010, 2'b00, tb});
            if (rb != rstate) begin
              rcnt++;
              if (rcnt >= rthr) begin rstate = rb; rcnt = 0; end
            end else rcnt = 0;
            if (trun == 0 || tb != tlast) begin trun = 1; tlast = tb; end
            else if (trun < 5) trun++;
            if (sr) chk("R4 defect sweep", rdi_defect, rstate);
            else    chk("R3 defect sweep", rdi_defect, rstate);
            if (st) chk("R6 tm sweep", tm_valid, trun >= tthr);
            else    chk("R5 tm sweep", tm_valid, trun >= tthr);
            if (trun >= tthr) chk("R5 tm value", tm_value, tlast);
          end
        end

    // R8 select change keeps state
    do_reset();
    repeat (3) frame(8'h91);
    chk("R8 declared at 3", rdi_defect, 1);
    chk("R8 tm valid at 3", tm_valid, 1);
    wr(2'd0, 8'h1A);
    chk("R8 defect kept on switch", rdi_defect, 1);
    chk("R8 tm kept until frame", tm_valid, 1);
    frame(8'h11);
    chk("R8 tm needs 5 now", tm_valid, 0);
    repeat (3) frame(8'h11);
    chk("R8 defect held after 4 clear", rdi_defect, 1);
    chk("R8 tm valid after 5", tm_valid, 1);
    frame(8'h11);
    chk("R8 cleared at 5", rdi_defect, 0);

    // R7 mismatch sweep
    do_reset();
    wr(2'd1, 8'h01);
    for (int e = 0; e < 8; e++)
      for (int p = 0; p < 8; p++) begin
        wr(2'd0, {5'b00000, e[2:0]});
        frame({2'b00, p[2:0], 3'b000});
        chk("R7 irq sweep", pt_irq, p != e);
        rd(2'd2, d); chk("R7 status sweep", d[0], p != e);
        wr(2'd2, 8'h01);
      end
    wr(2'd0, 8'h02);
    frame(8'h08);
    chk("R7 set", pt_irq, 1);
    frame(8'h10);
    chk("R7 sticky on match", pt_irq, 1);
    wr(2'd2, 8'h00); chk("R7 write0 no clear", pt_irq, 1);
    wr(2'd2, 8'h01); chk("R7 w1c", pt_irq, 0);
    wr(2'd1, 8'h00);
    frame(8'h08);
    chk("R7 enable gate", pt_irq, 0);
    rd(2'd2, d); chk("R7 enable gate status", d[0], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule